// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers rising edges on a set of peripheral request lines into pending bits and presents a single interrupt line and a handler vector to a simple processor. Line 0 has the highest priority, and each higher index ranks one step lower. A request that cannot be served at once stays pending until it can. Once acknowledged, the request moves from pending to in-service, and the processor reads its vector.

Software picks one of two modes with a configuration write. That write also sets the global enable. In sequential mode no new interrupt is raised while any handler is in service. In nested mode a request that strictly outranks every in-service handler preempts it. The in-service bits act as the stack of active handlers. An end-of-handler strobe retires the highest-priority one, so the preempted handler's priority level is restored.

Top module: `pic_nested_top`

## Requirements
- R1: Synchronous reset clears all pending and in-service bits, deasserts the global enable, selects sequential mode, and drives `cpu_irq` low and `irq_vec` to 0.
- R2: A 0-to-1 transition on `irq_in[i]` sets pending bit i. A line held high does not set it again. A pending bit is kept while the controller is disabled or busy, until that line is acknowledged.
- R3: `cpu_irq` is high exactly when the enable is set and the highest-priority pending line may be served. It updates on the same clock edge as the state change that causes it.
- R4: An `int_ack` pulse while `cpu_irq` is high loads the index of the served line into `irq_vec` on that edge. It also clears that line's pending bit and sets its in-service bit. An `int_ack` while `cpu_irq` is low changes nothing.
- R5: Among several pending lines, the lowest index is served first.
- R6: Sequential mode (`cfg_nested`=0): while any in-service bit is set, `cpu_irq` stays low, even for a higher-priority request.
- R7: Nested mode (`cfg_nested`=1): a pending line with a strictly lower index than every in-service line raises `cpu_irq`. A pending line of lower priority waits.
- R8: `int_eoi` clears the lowest-index in-service bit. A pending line that ranks between that handler and the preempted one is then served, and lower-ranked lines keep waiting.
- R9: On the edge where `int_eoi` retires the last blocking handler, `cpu_irq` rises if an eligible request is pending.
- R10: In nested mode, a new edge on a line that is already in service stays pending (equal priority waits). It is served after that handler ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N | Peripheral request lines, rising-edge sensitive |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_enable | input | 1 | Global enable value written by `cfg_wr` |
| cfg_nested | input | 1 | Mode written by `cfg_wr`: 0 sequential, 1 nested |
| int_ack | input | 1 | Processor acknowledge strobe |
| int_eoi | input | 1 | End-of-handler strobe |
| cpu_irq | output | 1 | Registered interrupt request to the processor |
| irq_vec | output | W | Registered index of the last acknowledged line |

## Verification
The bench drives a preemption chain in nested mode: a low-priority line enters service, a high-priority line preempts it, and after the end-of-handler a mid-priority request must still outrank the resumed handler. A design that retires the wrong in-service bit would either block that request or raise lower lines too early. The bench also checks that a line held high latches only once, since a level-sensitive latch would re-enter the same handler. It checks that a higher-priority request stays silent in sequential mode, that a stray acknowledge leaves the vector and the pending bits untouched, and that simultaneous edges are served in index order.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic {
    PIC_MODE_SEQ  = 1'b0,
    PIC_MODE_NEST = 1'b1
  } pic_mode_e;
endpackage

// File: rtl/pic_first_set.sv
// Finds the lowest-index set bit (the highest priority).
module pic_first_set #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] bits,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/pic_edge_latch.sv
// Rising-edge capture into pending bits, with per-line clear on grant.
module pic_edge_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] pend_n
);
  logic [N-1:0] prev_q;
  logic [N-1:0] rise;

  assign rise   = lines & ~prev_q;
  assign pend_n = (pend_q & ~clr) | rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lines;
      pend_q <= pend_n;
    end
  end
endmodule

// File: rtl/pic_isr_stack.sv
// In-service bits. Retirement removes the highest-priority active handler.
module pic_isr_stack #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         retire,
  output logic [N-1:0] isr_q,
  output logic [N-1:0] isr_n
);
  logic [N-1:0] top_bit;

  assign top_bit = isr_q & (~isr_q + N'(1));
  assign isr_n   = (isr_q & ~(retire ? top_bit : '0)) | set;

  always_ff @(posedge clk) begin
    if (rst) isr_q <= '0;
    else     isr_q <= isr_n;
  end
endmodule

// File: rtl/pic_nested_top.sv
module pic_nested_top
  import pic_pkg::*;
#(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq_in,
  input  logic         cfg_wr,
  input  logic         cfg_enable,
  input  logic         cfg_nested,
  input  logic         int_ack,
  input  logic         int_eoi,
  output logic         cpu_irq,
  output logic [W-1:0] irq_vec
);
  logic         en_q, en_n;
  pic_mode_e    mode_q, mode_n;
  logic         nest_on;
  logic [W-1:0] win_q;
  logic         grant;
  logic [N-1:0] grant_oh;
  logic [N-1:0] pend_q, pend_n, isr_q, isr_n;
  logic         p_found, s_found;
  logic [W-1:0] p_idx, s_idx;
  logic         serve_n;

  assign en_n    = cfg_wr ? cfg_enable : en_q;
  assign mode_n  = cfg_wr ? pic_mode_e'(cfg_nested) : mode_q;
  assign nest_on = (mode_q == PIC_MODE_NEST);

  assign grant = int_ack & cpu_irq;

  generate
    for (genvar g = 0; g < N; g++) begin : g_oh
      assign grant_oh[g] = grant && (win_q == W'(g));
    end
  endgenerate

  pic_edge_latch #(.N(N)) u_pend (
    .clk(clk), .rst(rst), .lines(irq_in), .clr(grant_oh),
    .pend_q(pend_q), .pend_n(pend_n)
  );

  pic_isr_stack #(.N(N)) u_isr (
    .clk(clk), .rst(rst), .set(grant_oh), .retire(int_eoi),
    .isr_q(isr_q), .isr_n(isr_n)
  );

  pic_first_set #(.N(N)) u_pfs (.bits(pend_n), .found(p_found), .idx(p_idx));
  pic_first_set #(.N(N)) u_sfs (.bits(isr_n),  .found(s_found), .idx(s_idx));

  always_comb begin
    serve_n = 1'b0;
    if (en_n && p_found) begin
      if (!s_found)                      serve_n = 1'b1;
      else if (mode_n == PIC_MODE_NEST)  serve_n = (p_idx < s_idx);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      mode_q  <= PIC_MODE_SEQ;
      cpu_irq <= 1'b0;
      win_q   <= '0;
      irq_vec <= '0;
    end else begin
      en_q    <= en_n;
      mode_q  <= mode_n;
      cpu_irq <= serve_n;
      win_q   <= p_idx;
      if (grant) irq_vec <= win_q;
    end
  end
endmodule

// File: rtl/pic_nested_chk.sv
module pic_nested_chk #(
  parameter int N = 8,
  parameter int W = 3
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         nested,
  input logic         int_ack,
  input logic         int_eoi,
  input logic         cpu_irq,
  input logic [W-1:0] irq_vec,
  input logic [W-1:0] win,
  input logic [N-1:0] pend,
  input logic [N-1:0] insvc
);
  function automatic int lowest(input logic [N-1:0] v);
    int r;
    r = N;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |-> !cpu_irq);

  a_r2_pending_kept: assert property (@(posedge clk) disable iff (rst)
    !(int_ack && cpu_irq) |=> ((pend & $past(pend)) == $past(pend)));

  a_r4_vector_loaded: assert property (@(posedge clk) disable iff (rst)
    (int_ack && cpu_irq) |=> (irq_vec == $past(win)));

  a_r4_stray_ack: assert property (@(posedge clk) disable iff (rst)
    (int_ack && !cpu_irq && !int_eoi) |=> ($stable(irq_vec) && $stable(insvc)));

  a_r6_seq_blocks: assert property (@(posedge clk) disable iff (rst)
    (!nested && (|insvc)) |-> !cpu_irq);

  a_r7_outranks: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> (int'(win) < lowest(insvc)));

  a_r8_retire_one: assert property (@(posedge clk) disable iff (rst)
    (int_eoi && !(int_ack && cpu_irq) && (|insvc))
      |=> ($countones(insvc) + 1 == $countones($past(insvc))));
endmodule

bind pic_nested_top pic_nested_chk #(.N(N), .W(W)) chk_i (
  .clk(clk), .rst(rst), .en(en_q), .nested(nest_on),
  .int_ack(int_ack), .int_eoi(int_eoi), .cpu_irq(cpu_irq),
  .irq_vec(irq_vec), .win(win_q), .pend(pend_q), .insvc(isr_q)
);

// File: tb/pic_nested_top_tb_top.sv
`timescale 1ns/1ps
module pic_nested_top_tb_top;
  localparam int N = 8;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] irq_in = '0;
  logic cfg_wr = 0, cfg_enable = 0, cfg_nested = 0, int_ack = 0, int_eoi = 0;
  logic cpu_irq;
  logic [W-1:0] irq_vec;

  int total = 0;
  int bad = 0;
  int exp_q[$];
  event ack_done;

  always #5 clk = ~clk;

  pic_nested_top #(.N(N)) dut_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_wr(cfg_wr),
    .cfg_enable(cfg_enable), .cfg_nested(cfg_nested), .int_ack(int_ack),
    .int_eoi(int_eoi), .cpu_irq(cpu_irq), .irq_vec(irq_vec)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edge_step();
    @(posedge clk); #1;
  endtask

  task automatic cfg(input logic en, input logic nest);
    @(negedge clk); cfg_wr = 1; cfg_enable = en; cfg_nested = nest;
    edge_step(); cfg_wr = 0;
  endtask

  task automatic raise(input logic [N-1:0] m);
    @(negedge clk); irq_in = irq_in | m;
    edge_step();
  endtask

  task automatic drop(input logic [N-1:0] m);
    @(negedge clk); irq_in = irq_in & ~m;
    edge_step();
  endtask

  task automatic pulse(input logic [N-1:0] m);
    raise(m); drop(m);
  endtask

  // Driver: pushes the expected vector, then acknowledges.
  task automatic ack(input int exp_vec);
    exp_q.push_back(exp_vec);
    @(negedge clk); int_ack = 1;
    edge_step(); int_ack = 0;
    -> ack_done;
  endtask

  task automatic eoi();
    @(negedge clk); int_eoi = 1;
    edge_step(); int_eoi = 0;
  endtask

  // Monitor: compares the vector produced by each acknowledge.
  initial begin
    forever begin
      @(ack_done);
      if (exp_q.size() > 0) chk("R4 vector", int'(irq_vec), exp_q.pop_front());
    end
  end

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) edge_step();
    chk("R1 irq after reset", cpu_irq, 0);
    chk("R1 vec after reset", irq_vec, 0);
    @(negedge clk); rst = 0;
    edge_step();

    // R2: pending kept while disabled, served once enabled
    pulse(8'h20);
    chk("R2 disabled no irq", cpu_irq, 0);
    cfg(1, 0);
    chk("R3 irq on enable", cpu_irq, 1);
    ack(5);
    chk("R4 irq drops after ack", cpu_irq, 0);

    // R6: sequential mode blocks a higher request
    pulse(8'h02);
    chk("R6 seq blocks higher", cpu_irq, 0);
    eoi();
    chk("R9 irq on eoi", cpu_irq, 1);
    ack(1);
    eoi();
    chk("R9 idle after eoi", cpu_irq, 0);

    // R5: simultaneous edges served lowest index first
    pulse(8'h58);
    chk("R5 irq simultaneous", cpu_irq, 1);
    ack(3); eoi();
    ack(4); eoi();
    ack(6); eoi();
    chk("R5 all served", cpu_irq, 0);

    // R2: held level latches once
    raise(8'h04);
    ack(2); eoi();
    edge_step();
    chk("R2 held level no relatch", cpu_irq, 0);
    drop(8'h04);

    // Nested mode chain
    cfg(1, 1);
    pulse(8'h10);
    ack(4);
    pulse(8'h40);
    chk("R7 lower waits", cpu_irq, 0);
    pulse(8'h10);
    chk("R10 equal waits", cpu_irq, 0);
    pulse(8'h04);
    chk("R7 higher preempts", cpu_irq, 1);
    ack(2);
    chk("R7 no irq under 2", cpu_irq, 0);
    eoi();
    chk("R8 handler 4 restored", cpu_irq, 0);
    pulse(8'h08);
    chk("R8 mid line outranks 4", cpu_irq, 1);
    ack(3); eoi();
    chk("R8 back under 4", cpu_irq, 0);
    eoi();
    chk("R10 repeat 4 served", cpu_irq, 1);
    ack(4); eoi();
    ack(6); eoi();
    chk("R8 stack empty", cpu_irq, 0);

    // R4: stray acknowledge ignored
    @(negedge clk); int_ack = 1;
    edge_step(); int_ack = 0;
    chk("R4 stray ack vec", irq_vec, 6);
    chk("R4 stray ack irq", cpu_irq, 0);
    pulse(8'h80);
    ack(7); eoi();

    // R3: disabling masks a pending line
    cfg(0, 1);
    pulse(8'h01);
    chk("R3 disabled masks", cpu_irq, 0);
    cfg(1, 1);
    chk("R3 re-enable raises", cpu_irq, 1);
    ack(0); eoi();

    edge_step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule